// File: doc/BRIEF.md
# Fanout-Splitting Multicast Crossbar Scheduler

This block decides, once per time slot, which cells an N x N input-queued switch moves across a crossbar that can copy one input cell to any number of outputs at once. Each input has several queues. For each queue the block sees one valid bit and the destination mask of the cell at the head of that queue. The block returns a conflict-free decision. For each input it gives a grant flag, the index of the chosen queue and the set of outputs granted to that input's cell.

A cell may be served toward only part of its destinations. Outputs are handed out greedily. Inputs are visited in a rotating order whose first input moves on by one every slot. When its turn comes, each input takes the queue whose head cell reaches the most outputs that are still unclaimed. Any output it receives is then removed from the outputs available to the inputs visited after it. Queue storage and the fabric datapath are outside this block.

Top module: `mcs_sched`

## Requirements
- R1: During and after reset, `sched_done` and every `gnt_valid` bit are 0, every `gnt_mask` bit is 0, and the first slot after reset starts its visiting order at input 0.
- R2: A decision is taken only at a clock edge where `slot_go` is 1. Its results appear on the outputs in the following cycle, with `sched_done` high for exactly that cycle. While `slot_go` is 0, the grant outputs hold their values.
- R3: Across all inputs, each output is granted to at most one input per slot.
- R4: For an input with `gnt_valid` high, `gnt_mask` is a subset of the head fanout of the queue named by `gnt_queue`.
- R5: A queue whose valid bit is 0 is never chosen, whatever its fanout bits hold.
- R6: An input chooses the valid queue whose fanout covers the largest number of still-unclaimed outputs. On a tie, it chooses the lowest queue index.
- R7: The visiting order in a slot is input p, then p+1 and so on modulo PORTS. p is 0 for the first slot after reset and goes up by one, wrapping, on each later slot.
- R8: An input's grant is its chosen fanout ANDed with the outputs that no earlier-visited input claimed in that slot. If that set is empty, `gnt_valid` is 0 and the row of `gnt_mask` is 0.
- R9: A single input may be granted any number of outputs in a slot, up to all of them, which serves its whole remaining fanout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_go | input | 1 | Take a decision for this slot |
| req_valid | input | PORTS*QUEUES | Queue non-empty flags; bit i*QUEUES+q is queue q of input i |
| req_fanout | input | PORTS*QUEUES*PORTS | Head fanout masks; bits (i*QUEUES+q)*PORTS +: PORTS belong to queue q of input i, bit o is output o |
| sched_done | output | 1 | High in the cycle the slot's decision is presented |
| gnt_valid | output | PORTS | Per-input grant flag |
| gnt_queue | output | PORTS*QW | Per-input chosen queue index, bits i*QW +: QW |
| gnt_mask | output | PORTS*PORTS | Per-input granted outputs, bits i*PORTS +: PORTS |

## Verification
The bench aims at slots where every input broadcasts. In those slots only the first visited input may win anything. A design that did not remove claimed outputs would grant one output twice, and one that rotated wrongly would favour the wrong input. Directed slots with equal-weight queues catch a tie-break that prefers the highest index. A slot with a wide but invalid queue catches a picker that ignores the valid bits. Random slots check a nearly saturated input, where the fanout ANDed with the free outputs is empty, and flag a design that asserts a grant with an empty mask. Idle cycles between slots show whether outputs drift when no slot is requested.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int MCS_MAX_PORTS   = 8;
    localparam int MCS_DEF_PORTS   = 4;
    localparam int MCS_DEF_QUEUES  = 4;

    // number of set bits in an output mask (ports up to MCS_MAX_PORTS)
    function automatic logic [3:0] mask_weight(input logic [MCS_MAX_PORTS-1:0] m);
        logic [3:0] n;
        n = '0;
        for (int b = 0; b < MCS_MAX_PORTS; b++) n = n + {3'b000, m[b]};
        return n;
    endfunction
endpackage

// File: rtl/mcs_queue_pick.sv
module mcs_queue_pick
    import mcs_pkg::*;
#(
    parameter int PORTS  = MCS_DEF_PORTS,
    parameter int QUEUES = MCS_DEF_QUEUES,
    parameter int QW     = (QUEUES > 1) ? $clog2(QUEUES) : 1
) (
    input  logic [QUEUES-1:0]       q_valid,
    input  logic [QUEUES*PORTS-1:0] q_fan,
    input  logic [PORTS-1:0]        free_out,
    output logic                    hit,
    output logic [QW-1:0]           sel,
    output logic [PORTS-1:0]        mask
);
    logic [3:0]       best_w;
    logic [PORTS-1:0] cand;
    logic [3:0]       w;

    always_comb begin
        best_w = '0;
        hit    = 1'b0;
        sel    = '0;
        mask   = '0;
        cand   = '0;
        w      = '0;
        for (int q = 0; q < QUEUES; q++) begin
            cand = q_fan[q*PORTS +: PORTS] & free_out;
            w    = mask_weight(MCS_MAX_PORTS'(cand));
            // strict compare keeps the lowest index on equal weight
            if (q_valid[q] && (w > best_w)) begin
                best_w = w;
                hit    = 1'b1;
                sel    = QW'(q);
                mask   = cand;
            end
        end
    end
endmodule

// File: rtl/mcs_claim_chain.sv
module mcs_claim_chain
    import mcs_pkg::*;
#(
    parameter int PORTS  = MCS_DEF_PORTS,
    parameter int QUEUES = MCS_DEF_QUEUES,
    parameter int QW     = (QUEUES > 1) ? $clog2(QUEUES) : 1,
    parameter int PW     = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [PW-1:0]                 start_in,
    input  logic [PORTS*QUEUES-1:0]       req_valid,
    input  logic [PORTS*QUEUES*PORTS-1:0] req_fanout,
    output logic [PORTS-1:0]              in_hit,
    output logic [PORTS*QW-1:0]           in_sel,
    output logic [PORTS*PORTS-1:0]        in_mask
);
    localparam int ROW = QUEUES * PORTS;

    logic [PW-1:0]     stg_idx   [PORTS];
    logic [QUEUES-1:0] stg_valid [PORTS];
    logic [ROW-1:0]    stg_fan   [PORTS];
    logic [PORTS-1:0]  stg_free  [PORTS+1];
    logic              stg_hit   [PORTS];
    logic [QW-1:0]     stg_sel   [PORTS];
    logic [PORTS-1:0]  stg_mask  [PORTS];

    // rotate: stage k serves input (start + k) mod PORTS
    always_comb begin
        for (int k = 0; k < PORTS; k++) begin
            int s;
            s = int'(start_in) + k;
            if (s >= PORTS) s = s - PORTS;
            stg_idx[k]   = PW'(s);
            stg_valid[k] = req_valid[s*QUEUES +: QUEUES];
            stg_fan[k]   = req_fanout[s*ROW +: ROW];
        end
    end

    assign stg_free[0] = '1;

    generate
        for (genvar k = 0; k < PORTS; k++) begin : g_stage
            mcs_queue_pick #(.PORTS(PORTS), .QUEUES(QUEUES), .QW(QW)) u_pick (
                .q_valid  (stg_valid[k]),
                .q_fan    (stg_fan[k]),
                .free_out (stg_free[k]),
                .hit      (stg_hit[k]),
                .sel      (stg_sel[k]),
                .mask     (stg_mask[k])
            );
            assign stg_free[k+1] = stg_free[k] & ~stg_mask[k];
        end
    endgenerate

    // un-rotate back to input order
    always_comb begin
        in_hit  = '0;
        in_sel  = '0;
        in_mask = '0;
        for (int k = 0; k < PORTS; k++) begin
            in_hit[stg_idx[k]]                = stg_hit[k];
            in_sel[stg_idx[k]*QW +: QW]       = stg_sel[k];
            in_mask[stg_idx[k]*PORTS +: PORTS] = stg_mask[k];
        end
    end
endmodule

// File: rtl/mcs_sched.sv
module mcs_sched
    import mcs_pkg::*;
#(
    parameter int PORTS  = MCS_DEF_PORTS,
    parameter int QUEUES = MCS_DEF_QUEUES,
    parameter int QW     = (QUEUES > 1) ? $clog2(QUEUES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          slot_go,
    input  logic [PORTS*QUEUES-1:0]       req_valid,
    input  logic [PORTS*QUEUES*PORTS-1:0] req_fanout,
    output logic                          sched_done,
    output logic [PORTS-1:0]              gnt_valid,
    output logic [PORTS*QW-1:0]           gnt_queue,
    output logic [PORTS*PORTS-1:0]        gnt_mask
);
    localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1;

    logic [PW-1:0]          start_q;
    logic [PORTS-1:0]       nxt_hit;
    logic [PORTS*QW-1:0]    nxt_sel;
    logic [PORTS*PORTS-1:0] nxt_mask;

    mcs_claim_chain #(.PORTS(PORTS), .QUEUES(QUEUES), .QW(QW), .PW(PW)) u_chain (
        .start_in   (start_q),
        .req_valid  (req_valid),
        .req_fanout (req_fanout),
        .in_hit     (nxt_hit),
        .in_sel     (nxt_sel),
        .in_mask    (nxt_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= '0;
            sched_done <= 1'b0;
            gnt_valid  <= '0;
            gnt_queue  <= '0;
            gnt_mask   <= '0;
        end else begin
            sched_done <= slot_go;
            if (slot_go) begin
                gnt_valid <= nxt_hit;
                gnt_queue <= nxt_sel;
                gnt_mask  <= nxt_mask;
                start_q   <= (int'(start_q) == PORTS-1) ? '0 : start_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcs_sched_chk.sv
module mcs_sched_chk
    import mcs_pkg::*;
#(
    parameter int PORTS  = MCS_DEF_PORTS,
    parameter int QUEUES = MCS_DEF_QUEUES,
    parameter int QW     = (QUEUES > 1) ? $clog2(QUEUES) : 1
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          slot_go,
    input logic [PORTS*QUEUES-1:0]       req_valid,
    input logic [PORTS*QUEUES*PORTS-1:0] req_fanout,
    input logic                          sched_done,
    input logic [PORTS-1:0]              gnt_valid,
    input logic [PORTS*QW-1:0]           gnt_queue,
    input logic [PORTS*PORTS-1:0]        gnt_mask
);
    logic [PORTS*QUEUES-1:0]       val_hold;
    logic [PORTS*QUEUES*PORTS-1:0] fan_hold;
    logic [PORTS-1:0]              col      [PORTS];
    logic [PORTS-1:0]              fan_sel  [PORTS];
    logic                          val_sel  [PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            val_hold <= '0;
            fan_hold <= '0;
        end else if (slot_go) begin
            val_hold <= req_valid;
            fan_hold <= req_fanout;
        end
    end

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            int q;
            q = int'(gnt_queue[i*QW +: QW]);
            fan_sel[i] = fan_hold[(i*QUEUES + q)*PORTS +: PORTS];
            val_sel[i] = val_hold[i*QUEUES + q];
            for (int o = 0; o < PORTS; o++) col[o][i] = gnt_mask[i*PORTS + o];
        end
    end

    // R2
    done_follows_go_chk: assert property (@(posedge clk) disable iff (rst)
        sched_done |-> $past(slot_go));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_go |=> ($stable(gnt_mask) && $stable(gnt_valid) && $stable(gnt_queue)));

    generate
        for (genvar g = 0; g < PORTS; g++) begin : g_chk
            // R3
            out_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot0(col[g]));

            // R4
            mask_in_fanout_chk: assert property (@(posedge clk) disable iff (rst)
                (sched_done && gnt_valid[g]) |-> ((gnt_mask[g*PORTS +: PORTS] & ~fan_sel[g]) == '0));

            // R5
            chosen_valid_chk: assert property (@(posedge clk) disable iff (rst)
                (sched_done && gnt_valid[g]) |-> val_sel[g]);

            // R8
            empty_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
                gnt_valid[g] == (gnt_mask[g*PORTS +: PORTS] != '0));
        end
    endgenerate
endmodule

bind mcs_sched mcs_sched_chk #(.PORTS(PORTS), .QUEUES(QUEUES), .QW(QW)) u_chk (.*);

// File: tb/mcs_sched_bench.sv
module mcs_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int Q  = 4;
    localparam int QW = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 slot_go = 1'b0;
    logic [P*Q-1:0]       req_valid = '0;
    logic [P*Q*P-1:0]     req_fanout = '0;
    logic                 sched_done;
    logic [P-1:0]         gnt_valid;
    logic [P*QW-1:0]      gnt_queue;
    logic [P*P-1:0]       gnt_mask;

    int checks = 0;
    int fails  = 0;
    int bptr   = 0;

    logic [P-1:0]    e_valid;
    logic [P*QW-1:0] e_queue;
    logic [P*P-1:0]  e_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcs_sched #(.PORTS(P), .QUEUES(Q), .QW(QW)) u_mcs_sched (
        .clk, .rst, .slot_go, .req_valid, .req_fanout,
        .sched_done, .gnt_valid, .gnt_queue, .gnt_mask
    );

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic int wt(input logic [P-1:0] m);
        int n = 0;
        for (int b = 0; b < P; b++) n += int'(m[b]);
        return n;
    endfunction

    // reference decision from the requirements (R5-R8)
    task automatic model(input int start);
        logic [P-1:0] freem;
        freem   = '1;
        e_valid = '0;
        e_queue = '0;
        e_mask  = '0;
        for (int k = 0; k < P; k++) begin
            int i = (start + k) % P;
            int best = 0;
            for (int q = 0; q < Q; q++) begin
                logic [P-1:0] c;
                c = req_fanout[(i*Q+q)*P +: P] & freem;
                if (req_valid[i*Q+q] && wt(c) > best) begin
                    best = wt(c);
                    e_valid[i] = 1'b1;
                    e_queue[i*QW +: QW] = QW'(q);
                    e_mask[i*P +: P] = c;
                end
            end
            freem = freem & ~e_mask[i*P +: P];
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one slot, sample the registered decision one edge later
    task automatic slot(input string tag);
        model(bptr);
        slot_go = 1'b1;
        @(negedge clk);
        slot_go = 1'b0;
        check("R2 done", 32'(sched_done), 32'd1);
        check({tag, " valid"}, 32'(gnt_valid), 32'(e_valid));
        check({tag, " mask"}, 32'(gnt_mask), 32'(e_mask));
        for (int i = 0; i < P; i++)
            if (e_valid[i]) check({tag, " R6 queue"}, 32'(gnt_queue[i*QW +: QW]), 32'(e_queue[i*QW +: QW]));
        for (int o = 0; o < P; o++) begin
            int n = 0;
            for (int i = 0; i < P; i++) n += int'(gnt_mask[i*P+o]);
            check("R3 exclusive", 32'(n <= 1), 32'd1);
        end
        bptr = (bptr + 1) % P;
    endtask

    task automatic set_q(input int i, input int q, input logic v, input logic [P-1:0] f);
        req_valid[i*Q+q] = v;
        req_fanout[(i*Q+q)*P +: P] = f;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset done", 32'(sched_done), 32'd0);
        check("R1 reset valid", 32'(gnt_valid), 32'd0);
        check("R1 reset mask", 32'(gnt_mask), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R7 R9: everyone broadcasts; start input takes all outputs
        req_valid = '0; req_fanout = '0;
        for (int i = 0; i < P; i++) set_q(i, 0, 1'b1, '1);
        slot("R9 broadcast");
        check("R7 first slot start 0", 32'(gnt_valid), 32'b0001);
        slot("R7 rotate");
        check("R7 second slot start 1", 32'(gnt_valid), 32'b0010);
        slot("R7 rotate");
        slot("R7 rotate");
        slot("R7 wrap");
        check("R7 wrap to 0", 32'(gnt_valid), 32'b0001);

        // R2: idle cycles hold outputs, done drops
        @(negedge clk);
        check("R2 done low", 32'(sched_done), 32'd0);
        check("R2 hold", 32'(gnt_mask), 32'(e_mask));

        // R6 tie: queues 1 and 2 equal weight -> queue 1
        req_valid = '0; req_fanout = '0;
        set_q(bptr, 1, 1'b1, 4'b0011);
        set_q(bptr, 2, 1'b1, 4'b1100);
        slot("R6 tie");
        check("R6 tie low index", 32'(gnt_queue[((bptr+P-1)%P)*QW +: QW]), 32'd1);

        // R5: invalid wide queue ignored
        req_valid = '0; req_fanout = '0;
        set_q(bptr, 0, 1'b0, 4'b1111);
        set_q(bptr, 3, 1'b1, 4'b0100);
        slot("R5 invalid");
        check("R5 invalid ignored", 32'(gnt_mask[((bptr+P-1)%P)*P +: P]), 32'b0100);

        // R8: later input fully blocked gets no grant
        req_valid = '0; req_fanout = '0;
        set_q(bptr, 0, 1'b1, 4'b0110);
        set_q((bptr+1)%P, 0, 1'b1, 4'b0010);
        slot("R8 blocked");
        check("R8 blocked no grant", 32'(gnt_valid[bptr]), 32'd0);

        // random slots with occasional idle gaps
        for (int n = 0; n < 400; n++) begin
            for (int b = 0; b < P*Q; b++) req_valid[b] = ($urandom % 3) != 0;
            for (int b = 0; b < P*Q; b++) req_fanout[b*P +: P] = P'($urandom);
            slot("R8 random");
            if ((n % 7) == 0) begin
                @(negedge clk);
                check("R2 idle hold", 32'(gnt_mask), 32'(e_mask));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule